// File: doc/BRIEF.md
# Serial Command Queue Sequencer

This block steps through a 32-entry command queue on behalf of a queued serial master. When software raises the enable, the block takes a snapshot of its control fields and loads the queue pointer with the programmed first address. Each time the shift engine strobes command-done, the block compares the address of the command that just finished with the programmed last address. If they differ, the pointer moves forward by one, rolling over from 31 to 0.

When the finished command's address equals the last address, the block sets a sticky finished flag. It then does one of two things. In stop mode it drops busy and holds the pointer. In wraparound mode it keeps running and restarts at either address zero or the captured first address. A finish interrupt request is raised while the finished flag is set and the captured interrupt enable is 1. Software clears the flag with a one-cycle clear strobe.

Top module: `cmdq_seq_top`

## Requirements
- R1: After synchronous reset, queue_addr_o is 0 and busy_o, finished_o and irq_o are all 0.
- R2: A rising edge on run_en_i while the block is idle sets busy_o to 1 and queue_addr_o to first_addr_i one cycle later.
- R3: A cmd_done_i pulse while busy, with queue_addr_o not equal to the captured last address, makes queue_addr_o equal to (queue_addr_o + 1) mod 32 one cycle later.
- R4: A cmd_done_i pulse while busy, with queue_addr_o equal to the captured last address, sets finished_o one cycle later.
- R5: With wrap_on_i captured as 0, the end match clears busy_o, and queue_addr_o keeps the last address until a new rising edge of run_en_i.
- R6: With wrap_on_i captured as 1 and wrap_to_first_i captured as 0, the end match keeps busy_o at 1 and loads queue_addr_o with 0.
- R7: With wrap_on_i captured as 1 and wrap_to_first_i captured as 1, the end match keeps busy_o at 1 and loads queue_addr_o with the captured first address.
- R8: irq_o is 1 exactly when finished_o is 1 and the captured fin_irq_en_i is 1.
- R9: A one-cycle fin_clr_i clears finished_o on the next cycle. A clear in the same cycle as an end match wins, so finished_o is 0.
- R10: first_addr_i, last_addr_i, wrap_on_i, wrap_to_first_i and fin_irq_en_i are captured on the rising edge of run_en_i. Changes to them while busy do not affect the wrap target, the end match or irq_o.
- R11: cmd_done_i while busy_o is 0 changes neither queue_addr_o nor finished_o.
- R12: Dropping run_en_i while busy clears busy_o one cycle later. queue_addr_o is held, and a cmd_done_i in that same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en_i | input | 1 | Run enable; a rising edge starts the queue |
| first_addr_i | input | 5 | Programmed first queue address |
| last_addr_i | input | 5 | Programmed last queue address |
| wrap_on_i | input | 1 | 1 = continue after the last address |
| wrap_to_first_i | input | 1 | Wrap target: 0 = address 0, 1 = first address |
| fin_irq_en_i | input | 1 | Finish interrupt enable |
| cmd_done_i | input | 1 | Command-done strobe from the shift engine |
| fin_clr_i | input | 1 | One-cycle clear of the finished flag |
| queue_addr_o | output | 5 | Current queue address |
| busy_o | output | 1 | Sequencer is running |
| finished_o | output | 1 | Sticky end-of-queue flag |
| irq_o | output | 1 | Finish interrupt request |

## Verification
Every state change is registered once. The pointer, busy and finished outputs therefore take their new value on the first clock edge after the edge that samples the enable, done or clear input. irq_o is a combinational function of two registers, so it changes in that same cycle.

The bench changes inputs 1 ns after a rising edge. It reads outputs 1 ns after the next rising edge, so each check falls exactly one cycle after its stimulus. The bench also drops one-cycle strobes before the following edge, so no strobe is sampled twice.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    localparam int QA_W   = 5;
    localparam int QDEPTH = 1 << QA_W;

    typedef logic [QA_W-1:0] qaddr_t;

    typedef struct packed {
        qaddr_t first_addr;
        qaddr_t last_addr;
        logic   wrap_on;
        logic   wrap_to_first;
        logic   irq_en;
    } seq_cfg_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

    function automatic qaddr_t step_addr(input qaddr_t a);
        return qaddr_t'(a + 1'b1);
    endfunction

    function automatic qaddr_t wrap_target(input seq_cfg_t c);
        return c.wrap_to_first ? c.first_addr : '0;
    endfunction

endpackage

// File: rtl/cmdq_cfg_latch.sv
module cmdq_cfg_latch
    import cmdq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run_en_i,
    input  logic     busy_i,
    input  seq_cfg_t cfg_i,
    output logic     start_o,
    output seq_cfg_t cfg_q_o
);

    logic en_q;

    assign start_o = run_en_i && !en_q && !busy_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            cfg_q_o <= '0;
        end else begin
            en_q <= run_en_i;
            if (start_o) begin
                cfg_q_o <= cfg_i;
            end
        end
    end

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start_o |=> $stable(cfg_q_o));

endmodule

// File: rtl/cmdq_ptr_fsm.sv
module cmdq_ptr_fsm
    import cmdq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     run_en_i,
    input  logic     cmd_done_i,
    input  qaddr_t   first_addr_i,
    input  seq_cfg_t cfg_i,
    output qaddr_t   ptr_o,
    output logic     busy_o,
    output logic     eoq_hit_o
);

    seq_state_t state;
    logic       step_ok;
    logic       at_end;

    assign busy_o    = (state == ST_RUN);
    assign step_ok   = busy_o && run_en_i && cmd_done_i;
    assign at_end    = (ptr_o == cfg_i.last_addr);
    assign eoq_hit_o = step_ok && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ptr_o <= '0;
        end else if (start_i) begin
            state <= ST_RUN;
            ptr_o <= first_addr_i;
        end else if (busy_o) begin
            if (!run_en_i) begin
                state <= ST_IDLE;
            end else if (cmd_done_i) begin
                if (at_end) begin
                    if (cfg_i.wrap_on) begin
                        ptr_o <= wrap_target(cfg_i);
                    end else begin
                        state <= ST_IDLE;
                    end
                end else begin
                    ptr_o <= step_addr(ptr_o);
                end
            end
        end
    end

    // R2
    load_first_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (busy_o && ptr_o == $past(first_addr_i)));

    // R3
    step_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (step_ok && !at_end) |=> (ptr_o == qaddr_t'($past(ptr_o) + 1'b1)));

    // R5
    stop_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        (eoq_hit_o && !cfg_i.wrap_on) |=> (!busy_o && $stable(ptr_o)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(ptr_o));

    // R12
    drop_en_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !run_en_i && !start_i) |=> (!busy_o && $stable(ptr_o)));

endmodule

// File: rtl/cmdq_fin_flag.sv
module cmdq_fin_flag (
    input  logic clk,
    input  logic rst,
    input  logic eoq_hit_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic finished_o,
    output logic irq_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            finished_o <= 1'b0;
        end else if (clr_i) begin
            finished_o <= 1'b0;
        end else if (eoq_hit_i) begin
            finished_o <= 1'b1;
        end
    end

    assign irq_o = finished_o && irq_en_i;

    // R4
    set_on_end_chk: assert property (@(posedge clk) disable iff (rst)
        (eoq_hit_i && !clr_i) |=> finished_o);

    // R9
    clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !finished_o);

    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (finished_o && !clr_i) |=> finished_o);

endmodule

// File: rtl/cmdq_seq_top.sv
module cmdq_seq_top
    import cmdq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run_en_i,
    input  logic [4:0] first_addr_i,
    input  logic [4:0] last_addr_i,
    input  logic       wrap_on_i,
    input  logic       wrap_to_first_i,
    input  logic       fin_irq_en_i,
    input  logic       cmd_done_i,
    input  logic       fin_clr_i,
    output logic [4:0] queue_addr_o,
    output logic       busy_o,
    output logic       finished_o,
    output logic       irq_o
);

    seq_cfg_t cfg_live;
    seq_cfg_t cfg_q;
    logic     start;
    logic     eoq_hit;
    qaddr_t   ptr;

    always_comb begin
        cfg_live.first_addr    = first_addr_i;
        cfg_live.last_addr     = last_addr_i;
        cfg_live.wrap_on       = wrap_on_i;
        cfg_live.wrap_to_first = wrap_to_first_i;
        cfg_live.irq_en        = fin_irq_en_i;
    end

    cmdq_cfg_latch u_cfg (
        .clk      (clk),
        .rst      (rst),
        .run_en_i (run_en_i),
        .busy_i   (busy_o),
        .cfg_i    (cfg_live),
        .start_o  (start),
        .cfg_q_o  (cfg_q)
    );

    cmdq_ptr_fsm u_ptr (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start),
        .run_en_i     (run_en_i),
        .cmd_done_i   (cmd_done_i),
        .first_addr_i (first_addr_i),
        .cfg_i        (cfg_q),
        .ptr_o        (ptr),
        .busy_o       (busy_o),
        .eoq_hit_o    (eoq_hit)
    );

    cmdq_fin_flag u_fin (
        .clk        (clk),
        .rst        (rst),
        .eoq_hit_i  (eoq_hit),
        .clr_i      (fin_clr_i),
        .irq_en_i   (cfg_q.irq_en),
        .finished_o (finished_o),
        .irq_o      (irq_o)
    );

    assign queue_addr_o = ptr;

    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (eoq_hit && cfg_q.wrap_on && !cfg_q.wrap_to_first) |=> (busy_o && queue_addr_o == '0));

    // R7
    wrap_first_chk: assert property (@(posedge clk) disable iff (rst)
        (eoq_hit && cfg_q.wrap_on && cfg_q.wrap_to_first) |=> (busy_o && queue_addr_o == $past(cfg_q.first_addr)));

    // R8
    irq_needs_fin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> finished_o);

endmodule

// File: tb/sim_cmdq_seq_top.sv
module sim_cmdq_seq_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_en_i = 1'b0;
    logic [4:0] first_addr_i = '0;
    logic [4:0] last_addr_i = '0;
    logic       wrap_on_i = 1'b0;
    logic       wrap_to_first_i = 1'b0;
    logic       fin_irq_en_i = 1'b0;
    logic       cmd_done_i = 1'b0;
    logic       fin_clr_i = 1'b0;
    logic [4:0] queue_addr_o;
    logic       busy_o;
    logic       finished_o;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #2 clk = ~clk;

    cmdq_seq_top u0 (
        .clk(clk), .rst(rst), .run_en_i(run_en_i),
        .first_addr_i(first_addr_i), .last_addr_i(last_addr_i),
        .wrap_on_i(wrap_on_i), .wrap_to_first_i(wrap_to_first_i),
        .fin_irq_en_i(fin_irq_en_i), .cmd_done_i(cmd_done_i),
        .fin_clr_i(fin_clr_i), .queue_addr_o(queue_addr_o),
        .busy_o(busy_o), .finished_o(finished_o), .irq_o(irq_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic begin_run(input int s, input int e, input bit w,
                             input bit ws, input bit ie);
        run_en_i = 1'b0;
        tick();
        first_addr_i = 5'(s); last_addr_i = 5'(e);
        wrap_on_i = w; wrap_to_first_i = ws; fin_irq_en_i = ie;
        run_en_i = 1'b1;
        tick();
        chk("R2 busy", int'(busy_o), 1);
        chk("R2 addr", int'(queue_addr_o), s);
    endtask

    task automatic done_pulse();
        cmd_done_i = 1'b1;
        tick();
        cmd_done_i = 1'b0;
    endtask

    task automatic clear_fin();
        fin_clr_i = 1'b1;
        tick();
        fin_clr_i = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        tick();
        chk("R1 addr", int'(queue_addr_o), 0);
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 fin", int'(finished_o), 0);
        chk("R1 irq", int'(irq_o), 0);
    endtask

    task automatic t_step_and_drop();
        begin_run(3, 6, 1'b0, 1'b0, 1'b0);
        done_pulse();
        chk("R3 step", int'(queue_addr_o), 4);
        done_pulse();
        chk("R3 step", int'(queue_addr_o), 5);
        run_en_i = 1'b0;
        cmd_done_i = 1'b1;
        tick();
        cmd_done_i = 1'b0;
        chk("R12 busy", int'(busy_o), 0);
        chk("R12 addr", int'(queue_addr_o), 5);
        done_pulse();
        chk("R11 addr", int'(queue_addr_o), 5);
        chk("R11 fin", int'(finished_o), 0);
    endtask

    task automatic t_rollover_stop();
        begin_run(30, 1, 1'b0, 1'b0, 1'b0);
        done_pulse();
        chk("R3 31", int'(queue_addr_o), 31);
        done_pulse();
        chk("R3 roll", int'(queue_addr_o), 0);
        done_pulse();
        chk("R3 1", int'(queue_addr_o), 1);
        chk("R4 not yet", int'(finished_o), 0);
        done_pulse();
        chk("R4 fin", int'(finished_o), 1);
        chk("R5 busy", int'(busy_o), 0);
        chk("R5 addr", int'(queue_addr_o), 1);
        done_pulse();
        chk("R5 hold", int'(queue_addr_o), 1);
        clear_fin();
        chk("R9 clr", int'(finished_o), 0);
    endtask

    task automatic t_wrap_zero();
        begin_run(2, 3, 1'b1, 1'b0, 1'b0);
        done_pulse();
        done_pulse();
        chk("R6 fin", int'(finished_o), 1);
        chk("R6 addr", int'(queue_addr_o), 0);
        chk("R6 busy", int'(busy_o), 1);
        clear_fin();
    endtask

    task automatic t_wrap_first_and_clear();
        begin_run(7, 8, 1'b1, 1'b1, 1'b0);
        done_pulse();
        done_pulse();
        chk("R7 addr", int'(queue_addr_o), 7);
        chk("R7 busy", int'(busy_o), 1);
        chk("R7 fin", int'(finished_o), 1);
        clear_fin();
        chk("R9 clr", int'(finished_o), 0);
        done_pulse();
        chk("R7 addr 8", int'(queue_addr_o), 8);
        fin_clr_i = 1'b1;
        cmd_done_i = 1'b1;
        tick();
        fin_clr_i = 1'b0;
        cmd_done_i = 1'b0;
        chk("R9 clr wins", int'(finished_o), 0);
        chk("R7 rewrap", int'(queue_addr_o), 7);
    endtask

    task automatic t_irq();
        begin_run(10, 10, 1'b0, 1'b0, 1'b1);
        done_pulse();
        chk("R8 irq on", int'(irq_o), 1);
        clear_fin();
        chk("R8 irq off", int'(irq_o), 0);
        begin_run(10, 10, 1'b0, 1'b0, 1'b0);
        done_pulse();
        chk("R8 fin", int'(finished_o), 1);
        chk("R8 masked", int'(irq_o), 0);
        clear_fin();
    endtask

    task automatic t_cfg_capture();
        begin_run(4, 5, 1'b1, 1'b1, 1'b1);
        first_addr_i = 5'd9; last_addr_i = 5'd7;
        wrap_to_first_i = 1'b0; wrap_on_i = 1'b0; fin_irq_en_i = 1'b0;
        done_pulse();
        chk("R10 step", int'(queue_addr_o), 5);
        chk("R10 no early fin", int'(finished_o), 0);
        done_pulse();
        chk("R10 fin", int'(finished_o), 1);
        chk("R10 wrap tgt", int'(queue_addr_o), 4);
        chk("R10 busy", int'(busy_o), 1);
        chk("R10 irq", int'(irq_o), 1);
        clear_fin();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_step_and_drop();
        t_rollover_stop();
        t_wrap_zero();
        t_wrap_first_and_clear();
        t_irq();
        t_cfg_capture();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule